// File: doc/BRIEF.md
# Time-of-Day Alarm Matcher with Interrupt Flag Register

This block sits beside a clock/calendar counter. Each time the counter finishes its once-a-second advance, it pulses an update strobe. On that strobe the block compares the current seconds, minutes and hours bytes with three alarm bytes. An alarm byte whose two top bits are both set acts as a wildcard. With wildcards, a single comparator gives alarms at rates from once a day down to once a second.

The block keeps three event flags: a periodic flag, an alarm flag and an update-finished flag. It also keeps an enable bit for each flag. A flag is set whenever its event occurs, whatever its enable says. The enables only decide whether a set flag pulls the interrupt request low. The request is modelled as an open-drain line: a drive value that is low whenever it is driven, plus an output-enable. When the output-enable is low, the line is released.

Software reads the flag byte through a read strobe. The read returns the current value and then clears every flag. Raising the set-mode input forces the update-finished enable to zero and keeps it there.

Top module: `alarm_flag_unit`

## Requirements
- R1: An alarm byte with bits 7 and 6 both 1 (any value 0xC0 to 0xFF) matches every value of its time byte.
- R2: On an update strobe, the alarm flag is set only if all three time bytes match their alarm bytes. A mismatch in any byte leaves it clear.
- R3: A wildcard in the hours alarm alone raises the alarm whenever minutes and seconds match. Wildcards in hours and minutes raise it whenever seconds match.
- R4: A periodic tick sets the periodic flag even when its enable is 0. With that enable at 0, the flag does not assert the request.
- R5: Every update strobe sets the update-finished flag, whether or not the alarm matches.
- R6: The summary flag is the OR of (periodic flag AND its enable), (alarm flag AND its enable) and (update flag AND its enable). While the summary flag is 1, irq_oe is 1 and irq_n is 0. While it is 0, irq_oe is 0.
- R7: While set_mode is 1, the update enable is forced to 0, and an enable write cannot set it.
- R8: The flag byte holds the summary flag in bit 7, the periodic flag in bit 6, the alarm flag in bit 5 and the update flag in bit 4. Bits 3 to 0 always read 0.
- R9: A read strobe leaves the flag byte unchanged in its own cycle. After the next clock edge all flags and the summary flag are 0, unless R10 applies.
- R10: An event that arrives in the same cycle as a read strobe sets its flag after the clear.
- R11: After reset, all flags and enables are 0 and irq_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_done | input | 1 | One-cycle pulse at the end of each one-second update |
| per_tick | input | 1 | One-cycle pulse at the selected periodic rate |
| rd_flags | input | 1 | One-cycle flag-byte read strobe |
| en_wr | input | 1 | Loads the three enable bits |
| en_per | input | 1 | Periodic enable value for en_wr |
| en_alm | input | 1 | Alarm enable value for en_wr |
| en_upd | input | 1 | Update enable value for en_wr |
| set_mode | input | 1 | Set mode; forces the update enable to 0 |
| cur_time | input | 24 | Current time {hours, minutes, seconds} |
| alm_time | input | 24 | Alarm {hours, minutes, seconds} |
| flags | output | 8 | Flag byte |
| irq_n | output | 1 | Interrupt drive value (low when driven) |
| irq_oe | output | 1 | Interrupt output-enable; 0 releases the line |

## Verification
The assertions assume that upd_done, per_tick and rd_flags are single-cycle pulses from a synchronous source. They also assume that the time and alarm bytes are stable in any cycle that carries an update strobe. The stimulus drives every input on the falling edge and holds it for exactly one cycle. This keeps each pulse one cycle long, and it presents the time and alarm values in the same cycle as the strobe they qualify.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int BYTE_W   = 8;
    localparam int N_FIELDS = 3;
    localparam int TIME_W   = BYTE_W * N_FIELDS;

    localparam int POS_SUM = 7;
    localparam int POS_PER = 6;
    localparam int POS_ALM = 5;
    localparam int POS_UPD = 4;

    typedef struct packed {
        logic per_f;
        logic alm_f;
        logic upd_f;
        logic per_e;
        logic alm_e;
        logic upd_e;
    } alm_state_t;
endpackage

// File: rtl/alm_byte_cmp.sv
module alm_byte_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur_b,
    input  logic [W-1:0] alm_b,
    output logic         hit
);
    logic wild;
    always_comb begin
        wild = alm_b[W-1] & alm_b[W-2];
        hit  = wild | (cur_b == alm_b);
    end
endmodule

// File: rtl/alm_match.sv
module alm_match #(
    parameter int W = 8,
    parameter int N = 3
) (
    input  logic [W*N-1:0] cur_t,
    input  logic [W*N-1:0] alm_t,
    output logic           all_hit
);
    logic [N-1:0] hits;

    for (genvar i = 0; i < N; i++) begin : g_field
        alm_byte_cmp #(.W(W)) u_cmp (
            .cur_b (cur_t[i*W +: W]),
            .alm_b (alm_t[i*W +: W]),
            .hit   (hits[i])
        );
    end

    always_comb all_hit = &hits;
endmodule

// File: rtl/alarm_flag_unit.sv
module alarm_flag_unit
    import alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_done,
    input  logic              per_tick,
    input  logic              rd_flags,
    input  logic              en_wr,
    input  logic              en_per,
    input  logic              en_alm,
    input  logic              en_upd,
    input  logic              set_mode,
    input  logic [TIME_W-1:0] cur_time,
    input  logic [TIME_W-1:0] alm_time,
    output logic [BYTE_W-1:0] flags,
    output logic              irq_n,
    output logic              irq_oe
);
    alm_state_t st_d, st_q;
    logic       match;
    logic       sum_f;

    alm_match #(.W(BYTE_W), .N(N_FIELDS)) u_match (
        .cur_t   (cur_time),
        .alm_t   (alm_time),
        .all_hit (match)
    );

    always_comb begin
        st_d = st_q;
        if (rd_flags) begin
            st_d.per_f = 1'b0;
            st_d.alm_f = 1'b0;
            st_d.upd_f = 1'b0;
        end
        if (per_tick)          st_d.per_f = 1'b1;
        if (upd_done)          st_d.upd_f = 1'b1;
        if (upd_done && match) st_d.alm_f = 1'b1;
        if (en_wr) begin
            st_d.per_e = en_per;
            st_d.alm_e = en_alm;
            st_d.upd_e = en_upd;
        end
        if (set_mode)          st_d.upd_e = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        sum_f = (st_q.per_f & st_q.per_e) |
                (st_q.alm_f & st_q.alm_e) |
                (st_q.upd_f & st_q.upd_e);
        flags          = '0;
        flags[POS_SUM] = sum_f;
        flags[POS_PER] = st_q.per_f;
        flags[POS_ALM] = st_q.alm_f;
        flags[POS_UPD] = st_q.upd_f;
        irq_oe         = sum_f;
        irq_n          = ~sum_f;
    end
endmodule

// File: rtl/alarm_flag_unit_chk.sv
module alarm_flag_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       upd_done,
    input logic       per_tick,
    input logic       rd_flags,
    input logic       set_mode,
    input logic       upd_en_q,
    input logic [7:0] flags,
    input logic       irq_n,
    input logic       irq_oe
);
    p_per_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        per_tick |=> flags[6]);

    p_upd_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> flags[4]);

    p_oe_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe |-> (flags[6] | flags[5] | flags[4]));

    p_drive_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe |-> !irq_n);

    p_set_kills_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_mode |=> !upd_en_q);

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flags && !per_tick && !upd_done) |=> (flags[7:4] == 4'h0 && !irq_oe));
endmodule

bind alarm_flag_unit alarm_flag_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_done (upd_done),
    .per_tick (per_tick),
    .rd_flags (rd_flags),
    .set_mode (set_mode),
    .upd_en_q (st_q.upd_e),
    .flags    (flags),
    .irq_n    (irq_n),
    .irq_oe   (irq_oe)
);

// File: tb/sim_alarm_flag_unit.sv
module sim_alarm_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_done = 0, per_tick = 0, rd_flags = 0, en_wr = 0;
    logic        en_per = 0, en_alm = 0, en_upd = 0, set_mode = 0;
    logic [23:0] cur_time = '0, alm_time = '0;
    logic [7:0]  flags;
    logic        irq_n, irq_oe;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    typedef struct {
        logic [7:0] exp_flags;
        string      tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    alarm_flag_unit u0 (
        .clk(clk), .rst_n(rst_n), .upd_done(upd_done), .per_tick(per_tick),
        .rd_flags(rd_flags), .en_wr(en_wr), .en_per(en_per), .en_alm(en_alm),
        .en_upd(en_upd), .set_mode(set_mode), .cur_time(cur_time),
        .alm_time(alm_time), .flags(flags), .irq_n(irq_n), .irq_oe(irq_oe)
    );

    // monitor: compares on the falling edge after each expected result
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (flags !== it.exp_flags || irq_oe !== it.exp_flags[7] ||
                (it.exp_flags[7] && irq_n !== 1'b0)) begin
                errors++;
                $display("FAIL %s: flags=%h oe=%b n=%b expected flags=%h oe=%b",
                         it.tag, flags, irq_oe, irq_n, it.exp_flags, it.exp_flags[7]);
            end
        end
    end

    // driver: one cycle of stimulus, then queue the expected outcome
    task automatic step(input logic tk, input logic up, input logic rd,
                        input logic ew, input logic [2:0] en, input logic st,
                        input logic [23:0] ct, input logic [23:0] at,
                        input logic [7:0] ef, input string tag);
        @(negedge clk);
        per_tick = tk; upd_done = up; rd_flags = rd; en_wr = ew;
        {en_per, en_alm, en_upd} = en; set_mode = st;
        cur_time = ct; alm_time = at;
        @(posedge clk);
        sb.push_back('{ef, tag});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R11 reset state
        step(0,0,0,0,3'b000,0, 24'h0, 24'h0, 8'h00, "R11 reset");
        // R4 tick with enable off; R8 bit 6
        step(1,0,0,0,3'b000,0, 24'h0, 24'h0, 8'h40, "R4 R8 per flag no irq");
        step(0,0,1,0,3'b000,0, 24'h0, 24'h0, 8'h00, "R9 read clears");
        // R5 / R2 mismatch in seconds
        step(0,1,0,0,3'b000,0, 24'h123045, 24'h123046, 8'h10, "R5 R2 mismatch");
        step(0,0,1,0,3'b000,0, 24'h0, 24'h0, 8'h00, "R9 read clears");
        // R2 exact match
        step(0,1,0,0,3'b000,0, 24'h123045, 24'h123045, 8'h30, "R2 full match");
        step(0,0,1,0,3'b000,0, 24'h0, 24'h0, 8'h00, "R9 read clears");
        // enable alarm only
        step(0,0,0,1,3'b010,0, 24'h0, 24'h0, 8'h00, "R6 enable write");
        // R3 hourly: hours wild, hours differ
        step(0,1,0,0,3'b010,0, 24'h073045, 24'hC03045, 8'hB0, "R3 R6 hourly");
        step(0,0,1,0,3'b010,0, 24'h0, 24'h0, 8'h00, "R9 R6 read releases");
        // R1 all wild
        step(0,1,0,0,3'b010,0, 24'h215917, 24'hC0FFC5, 8'hB0, "R1 all wild");
        // R10 read with concurrent tick
        step(1,0,1,0,3'b010,0, 24'h0, 24'h0, 8'h40, "R10 tick during read");
        step(0,0,1,0,3'b010,0, 24'h0, 24'h0, 8'h00, "R9 read clears");
        // R3 per minute
        step(0,1,0,0,3'b010,0, 24'h035945, 24'hFFC045, 8'hB0, "R3 per minute");
        step(0,0,1,0,3'b010,0, 24'h0, 24'h0, 8'h00, "R9 read clears");
        step(0,1,0,0,3'b010,0, 24'h035945, 24'hC0C046, 8'h10, "R3 R2 sec mismatch");
        step(0,0,1,0,3'b010,0, 24'h0, 24'h0, 8'h00, "R9 read clears");
        // R6 update enable
        step(0,1,0,1,3'b001,0, 24'h010203, 24'h000000, 8'h90, "R6 upd irq");
        // R7 set mode clears update enable
        step(0,0,0,0,3'b001,1, 24'h0, 24'h0, 8'h10, "R7 set clears enable");
        step(0,0,0,1,3'b001,1, 24'h0, 24'h0, 8'h10, "R7 write blocked");
        step(0,0,1,0,3'b001,0, 24'h0, 24'h0, 8'h00, "R9 read clears");
        // R4 periodic with enable
        step(1,0,0,1,3'b100,0, 24'h0, 24'h0, 8'hC0, "R4 R6 R8 per irq");
        step(0,0,1,0,3'b100,0, 24'h0, 24'h0, 8'h00, "R9 read clears");
        step(0,0,0,0,3'b100,0, 24'h0, 24'h0, 8'h00, "R8 idle");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule